// File: doc/BRIEF.md
# Effective-to-Real Page Translation Cache

This block is a small, fully associative cache of finished address translations. Each entry maps an effective page number directly to a real page number. A lookup that hits produces the full real address in the same cycle, so the segment and page translation stages are not used at all. There is no intermediate virtual address in the block. The page size is fixed at 4 KB. The low 12 bits of the effective address pass straight through as the page offset. The page numbers are 52 bits (effective) and 50 bits (real), which gives a 62-bit real address.

When a slower translation finishes somewhere else, its result is written in through the fill port. A fill for a page that is already cached rewrites that entry in place. A fill for a new page takes a free slot if one exists. When the cache is full, the fill evicts the least recently used entry, where both hits and fills count as uses. A single invalidate input empties the whole cache in one cycle. The entry count is a parameter: 128 by default, and 16 for quick simulation.

Top module: `ert_cache`

## Requirements
- R1: A lookup is purely combinational from the stored state. A lookup hits when a valid entry holds `lk_ea[63:12]`. On a hit, `lk_hit`=1 and `lk_ra` = {stored real page number, `lk_ea[11:0]`} in the same cycle.
- R2: On a lookup miss, `lk_hit`=0 and `lk_ra` is all zeros.
- R3: After reset every entry is invalid, so every lookup misses.
- R4: A fill whose page number is already cached overwrites that entry's real page number. All other mappings stay unchanged, and a page number is never held twice.
- R5: A fill of a new page number uses the lowest-index invalid entry when any entry is invalid. No valid mapping is lost while a free entry exists.
- R6: A fill of a new page number into a full cache replaces the least recently used entry. A use is a hit or a fill, and at reset the highest-index entry counts as the oldest.
- R7: A lookup hit makes that entry most recently used at the next clock edge. If a fill is accepted in the same cycle, the fill's recency update applies and the hit's does not.
- R8: `inv_all` clears every entry at the next edge. It takes priority over a fill in the same cycle, which is then dropped.
- R9: A fill becomes visible to lookups from the cycle after it is accepted. A lookup in the fill's own cycle sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_ea | input | 64 | Effective address to translate |
| lk_hit | output | 1 | Lookup hit flag |
| lk_ra | output | 62 | Translated real address, zero on a miss |
| fl_en | input | 1 | Fill request |
| fl_epn | input | 52 | Effective page number being filled |
| fl_rpn | input | 50 | Real page number being filled |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench keeps a use-stamp model of recency and checks it against the design. The main case is a full cache where one old entry is hit just before a new fill. A design that ignored hits in its recency order would evict that entry, and a later lookup would miss where a hit is expected. Other directed cases cover:
- a rewrite of a page that is already cached, where a design that allocated a fresh slot would leave two matches or lose an unrelated mapping;
- a lookup in the same cycle as the fill of the same page, which must still miss;
- an invalidate issued together with a fill, after which the filled page must not appear.

Random traffic over a small pool of pages then mixes hits, rewrites, evictions and occasional invalidates. This catches victim-selection or stale-free-slot errors that show up only after many reorderings.

// File: rtl/ert_pkg.sv
`timescale 1ns/1ps
package ert_pkg;
   localparam int unsigned ERT_EA_W = 64;
   localparam int unsigned ERT_RA_W = 62;
   localparam int unsigned ERT_PG_W = 12;

   typedef enum logic [1:0] {
      ACT_IDLE     = 2'd0,
      ACT_INV      = 2'd1,
      ACT_FILL_UPD = 2'd2,
      ACT_FILL_NEW = 2'd3
   } ert_act_e;
endpackage

// File: rtl/ert_match.sv
`timescale 1ns/1ps
module ert_match #(
   parameter int unsigned N     = 16,
   parameter int unsigned KEY_W = 52,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vld,
   input  logic [KEY_W-1:0] tags [N],
   input  logic [KEY_W-1:0] key,
   output logic [N-1:0]     hit_vec,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (tags[g] == key);
   end

   assign hit = |hit_vec;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) idx = idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/ert_free_pick.sv
`timescale 1ns/1ps
module ert_free_pick #(
   parameter int unsigned N = 16,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vld,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/ert_age_lru.sv
`timescale 1ns/1ps
module ert_age_lru #(
   parameter int unsigned N = 16,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] lru_idx
);
   localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

   logic [IDX_W-1:0] age_q [N];
   logic [IDX_W-1:0] tgt_age;
   logic [N-1:0]     is_old;

   assign tgt_age = age_q[touch_idx];

   for (genvar g = 0; g < N; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[g] <= IDX_W'(g);
         end else if (touch_en) begin
            if (touch_idx == IDX_W'(g))
               age_q[g] <= '0;
            else if (age_q[g] < tgt_age)
               age_q[g] <= age_q[g] + 1'b1;
         end
      end
      assign is_old[g] = (age_q[g] == AGE_MAX);
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (is_old[i]) lru_idx = lru_idx | IDX_W'(i);
      end
   end

   // R6
   single_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_old) == 1);

   // R7
   touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/ert_cache.sv
`timescale 1ns/1ps
module ert_cache
   import ert_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 128,
   parameter int unsigned EA_W      = ERT_EA_W,
   parameter int unsigned RA_W      = ERT_RA_W,
   parameter int unsigned PG_W      = ERT_PG_W,
   localparam int unsigned EPN_W    = EA_W - PG_W,
   localparam int unsigned RPN_W    = RA_W - PG_W,
   localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EA_W-1:0]  lk_ea,
   output logic             lk_hit,
   output logic [RA_W-1:0]  lk_ra,
   input  logic             fl_en,
   input  logic [EPN_W-1:0] fl_epn,
   input  logic [RPN_W-1:0] fl_rpn,
   input  logic             inv_all
);
   initial begin
      assert (N_ENTRIES >= 2 && PG_W > 0 && EA_W > PG_W && RA_W > PG_W)
         else $error("ert_cache: illegal parameter set");
   end

   logic [N_ENTRIES-1:0] vld_q;
   logic [EPN_W-1:0]     epn_q [N_ENTRIES];
   logic [RPN_W-1:0]     rpn_q [N_ENTRIES];

   logic [N_ENTRIES-1:0] lk_vec, fl_vec;
   logic                 lk_match, fl_match, any_free;
   logic [IDX_W-1:0]     lk_idx, fl_idx, free_idx, lru_idx, wr_idx, touch_idx;
   logic                 touch_en, wr_en;
   ert_act_e             act;

   ert_match #(.N(N_ENTRIES), .KEY_W(EPN_W)) u_lk_match (
      .vld(vld_q), .tags(epn_q), .key(lk_ea[EA_W-1:PG_W]),
      .hit_vec(lk_vec), .hit(lk_match), .idx(lk_idx));

   ert_match #(.N(N_ENTRIES), .KEY_W(EPN_W)) u_fl_match (
      .vld(vld_q), .tags(epn_q), .key(fl_epn),
      .hit_vec(fl_vec), .hit(fl_match), .idx(fl_idx));

   ert_free_pick #(.N(N_ENTRIES)) u_free (
      .vld(vld_q), .any_free(any_free), .free_idx(free_idx));

   ert_age_lru #(.N(N_ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
      .touch_idx(touch_idx), .lru_idx(lru_idx));

   always_comb begin
      if (inv_all)       act = ACT_INV;
      else if (!fl_en)   act = ACT_IDLE;
      else if (fl_match) act = ACT_FILL_UPD;
      else               act = ACT_FILL_NEW;
   end

   assign wr_en     = (act == ACT_FILL_UPD) || (act == ACT_FILL_NEW);
   assign wr_idx    = (act == ACT_FILL_UPD) ? fl_idx : (any_free ? free_idx : lru_idx);
   assign touch_en  = wr_en || ((act == ACT_IDLE) && lk_match);
   assign touch_idx = wr_en ? wr_idx : lk_idx;

   assign lk_hit = lk_match;
   assign lk_ra  = lk_match ? {rpn_q[lk_idx], lk_ea[PG_W-1:0]} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vld_q <= '0;
      else if (act == ACT_INV)
         vld_q <= '0;
      else if (wr_en)
         vld_q[wr_idx] <= 1'b1;
   end

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_store
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) begin
            epn_q[g] <= fl_epn;
            rpn_q[g] <= fl_rpn;
         end
      end
   end

   // R4
   no_dup_lk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   // R4
   no_dup_fl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fl_vec));

   // R8
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> !lk_hit);

   // R9
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fl_en && !inv_all) && lk_ea[EA_W-1:PG_W] == $past(fl_epn))
      |-> (lk_hit && lk_ra[RA_W-1:PG_W] == $past(fl_rpn)));
endmodule

// File: tb/ert_cache_tb.sv
`timescale 1ns/1ps
module ert_cache_tb_top;
   localparam int N = 16;
   localparam int POOL = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] lk_ea = '0;
   logic        lk_hit;
   logic [61:0] lk_ra;
   logic        fl_en = 1'b0;
   logic [51:0] fl_epn = '0;
   logic [49:0] fl_rpn = '0;
   logic        inv_all = 1'b0;

   int checks = 0;
   int errors = 0;

   bit          m_v  [N];
   logic [51:0] m_e  [N];
   logic [49:0] m_r  [N];
   int unsigned m_ts [N];
   int unsigned now;
   logic [51:0] pool [POOL];

   always #2.5 clk = ~clk;

   ert_cache #(.N_ENTRIES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_ra(lk_ra),
      .fl_en(fl_en), .fl_epn(fl_epn), .fl_rpn(fl_rpn), .inv_all(inv_all));

   function automatic int m_find(logic [51:0] e);
      for (int i = 0; i < N; i++) if (m_v[i] && m_e[i] == e) return i;
      return -1;
   endfunction

   function automatic int m_victim();
      int best = 0;
      for (int i = 0; i < N; i++) if (!m_v[i]) return i;
      for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[best]) best = i;
      return best;
   endfunction

   function automatic logic [62:0] m_expect(logic [63:0] ea);
      int j = m_find(ea[63:12]);
      if (j < 0) return '0;
      return {1'b1, m_r[j], ea[11:0]};
   endfunction

   task automatic cyc(bit inv, bit fe, logic [51:0] fepn, logic [49:0] frpn,
                      logic [63:0] lea, string tag);
      logic [62:0] exp_v;
      int j;
      @(negedge clk);
      inv_all = inv; fl_en = fe; fl_epn = fepn; fl_rpn = frpn; lk_ea = lea;
      #1;
      exp_v = m_expect(lea);
      checks++;
      if ({lk_hit, lk_ra} !== exp_v) begin
         errors++;
         $display("FAIL %s ea=%h hit/ra actual=%b/%h expected=%b/%h",
                  tag, lea, lk_hit, lk_ra, exp_v[62], exp_v[61:0]);
      end
      @(posedge clk);
      if (inv) begin
         for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      end else if (fe) begin
         j = m_find(fepn);
         if (j < 0) j = m_victim();
         m_v[j] = 1'b1; m_e[j] = fepn; m_r[j] = frpn; m_ts[j] = now++;
      end else begin
         j = m_find(lea[63:12]);
         if (j >= 0) m_ts[j] = now++;
      end
   endtask

   task automatic look(logic [63:0] lea, string tag);
      cyc(1'b0, 1'b0, '0, '0, lea, tag);
   endtask

   task automatic fill(logic [51:0] e, logic [49:0] r, string tag);
      cyc(1'b0, 1'b1, e, r, '0, tag);
   endtask

   initial begin
      #(2.5 * 2 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] t;
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin
         m_v[i] = 1'b0; m_e[i] = '0; m_r[i] = '0; m_ts[i] = N - 1 - i;
      end
      now = N;
      for (int i = 0; i < POOL; i++) begin
         t = {$urandom(), $urandom()};
         pool[i] = {t[51:5], 5'(i)};
      end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R3: empty after reset
      look({pool[0], 12'h123}, "R3");
      look({pool[5], 12'hfff}, "R3");
      look(64'h0, "R3");

      // R9: same-cycle lookup sees old contents; R1 next cycle hit
      cyc(1'b0, 1'b1, pool[0], 50'h2_aaaa_5555_1234, {pool[0], 12'h010}, "R9");
      look({pool[0], 12'habc}, "R1");
      // R2: miss on an absent page returns zero
      look({pool[1], 12'h777}, "R2");

      // R4: rewrite in place, neighbour kept
      fill(pool[1], 50'h111, "R4");
      fill(pool[0], 50'h3_0000_0000_0042, "R4");
      look({pool[0], 12'h001}, "R4");
      look({pool[1], 12'h002}, "R4");

      // R6/R7: fill 16 fresh pages, hit the first, then overflow
      cyc(1'b1, 1'b0, '0, '0, '0, "R8");
      for (int i = 0; i < N; i++) fill(pool[i], 50'(i + 100), "R5");
      for (int i = 0; i < N; i++) look({pool[i], 12'h5a5}, "R5");
      look({pool[0], 12'h000}, "R7");
      fill(pool[N], 50'h999, "R6");
      look({pool[0], 12'h444}, "R7");
      look({pool[1], 12'h444}, "R6");
      look({pool[N], 12'h444}, "R6");

      // R7: hit in same cycle as a fill does not refresh
      cyc(1'b0, 1'b1, pool[N+1], 50'h77, {pool[2], 12'h0}, "R7");
      look({pool[2], 12'h0}, "R7");

      // R8: invalidate beats a same-cycle fill
      cyc(1'b1, 1'b1, pool[N+2], 50'h55, {pool[3], 12'h0}, "R8");
      look({pool[N+2], 12'h0}, "R8");
      look({pool[3], 12'h0}, "R8");

      // R5: refill after invalidate loses nothing
      fill(pool[7], 50'h7, "R5");
      fill(pool[8], 50'h8, "R5");
      fill(pool[9], 50'h9, "R5");
      look({pool[7], 12'h1}, "R5");
      look({pool[8], 12'h1}, "R5");
      look({pool[9], 12'h1}, "R5");

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         int unsigned r = $urandom_range(99);
         int unsigned p = $urandom_range(POOL - 1);
         int unsigned q = $urandom_range(POOL - 1);
         logic [63:0] ea = {pool[q], 12'($urandom())};
         if (r < 2)       cyc(1'b1, r[0], pool[p], 50'($urandom()), ea, "R8");
         else if (r < 40) cyc(1'b0, 1'b1, pool[p], {18'($urandom()), 32'($urandom())}, ea, "R6");
         else             look(ea, "R1");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule